// File: doc/BRIEF.md
# Linked Descriptor Chain Copy Engine

This block is one channel of a memory-to-memory copy engine. Software places a chain of four-word descriptors in memory. Each descriptor gives a source address, a destination address, a link word and a byte count. Software then writes the address of the first descriptor into the current-descriptor register and raises the start bit of the mode register. The engine fetches each descriptor through its read port and copies the bytes one at a time, with a read followed by a write. It then moves on to the descriptor named by the link word, and it stops after a descriptor whose link word carries the end-of-list flag.

Because descriptors sit on 32-byte boundaries, the five low bits of a link word are free for flags. Bit 0 marks the end of the list. Bit 1 asks for an end-of-segment event once that descriptor is done. Bits 4:2 are ignored.

The engine also reports other conditions. A descriptor with a zero byte count is a programming error. A read or write that returns an error response is a transfer error. Each of these events sets a sticky status bit that software clears by writing one to it, and a single interrupt line collects the enabled status bits.

To stop the channel, software sets the abort bit, which puts the channel in a halted state, and then clears the start bit, which returns it to idle. Writing all zeros to the mode register resets the channel at once.

The sequencer states are:
- IDLE: waiting for a start edge.
- FETCH: reading the four descriptor words.
- DECODE: checking the byte count.
- READ and WRITE: moving one data byte.
- FINISH: reporting the descriptor's flags and following its link.
- HALT: parked after an abort.

The transitions are:
- IDLE to FETCH on a start edge.
- FETCH to FETCH for each of the first three words, and FETCH to DECODE on the fourth word.
- DECODE to READ when the count is nonzero, and DECODE to IDLE when it is zero.
- READ to WRITE on read data.
- WRITE to READ while bytes remain, and WRITE to FINISH on the last byte.
- FINISH to FETCH when the end-of-list flag is clear, and FINISH to IDLE when it is set.
- Any of FETCH, DECODE, READ, WRITE or FINISH to HALT on abort.
- HALT to IDLE once the start bit is clear.
- Any state to IDLE on an error response or a mode write of zero.

Register offsets on `reg_addr`:
- 0: mode.
- 1: status.
- 2: current descriptor.
- 3: next link.
- 4: remaining bytes.

Top module: `lnk_dma_seq`

## Requirements
- R1: After reset, mode and status read 0, `irq` is 0, and neither `rd_req` nor `wr_req` is asserted.
- R2: A 0-to-1 change of mode bit 0 starts the channel. The channel first reads the descriptor words at offsets +0, +4, +8 and +12 of the current-descriptor address (source, destination, link, count). It then copies count bytes in increasing address order, one read followed by one write per byte. A request holds its address until it is answered.
- R3: Link bits 31:5 give the next descriptor address, and link bits 4:2 are ignored. After finishing a descriptor whose link bit 0 is set, the channel goes idle (status bit 2 busy clear) and sets status bit 0 (end of list).
- R4: After finishing a descriptor whose link bit 1 is set, the channel sets status bit 1 (end of segment) and continues the chain.
- R5: A descriptor with a count of 0 causes no data read or write. It sets status bit 4 (programming error) and stops the channel without setting bit 0.
- R6: An error response on a read or a write sets status bit 5 (transfer error) and stops the channel. A write that receives an error response leaves memory unchanged, and no later bytes are written.
- R7: Writing status with a 1 in any of bits 0, 1, 4 or 5 clears that bit. Bit 2 (busy) and bit 3 (halted) reflect the channel state and cannot be written.
- R8: While the channel is busy, setting mode bit 1 (abort) puts it into the halted state one cycle later, and it issues no further requests. Once mode bit 0 is cleared, the channel returns to idle one cycle later, with busy and halted both clear.
- R9: Writing zero to mode returns the channel to idle on the next cycle and clears all status bits.
- R10: `irq` is the OR of three terms: status bit 0 with mode bit 6, status bit 1 with mode bit 5, and status bit 4 or 5 with mode bit 4.
- R11: Register 2 reads the 32-byte-aligned address of the current descriptor. Register 3 reads that descriptor's full link word. Register 4 reads the bytes still to copy. Writes to register 2 while the channel is busy are ignored.
- R12: Rewriting the mode register while its start bit is already 1 does not restart the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | AW | Read byte address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Read data, little-endian word starting at `rd_addr` |
| rd_err | input | 1 | Error flag qualified by `rd_valid` |
| wr_req | output | 1 | Write request, held until `wr_ack` |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 8 | Write data byte |
| wr_ack | input | 1 | Write response strobe |
| wr_err | input | 1 | Error flag qualified by `wr_ack` |
| irq | output | 1 | Interrupt, the OR of the enabled status bits |

## Verification
The hardest situation to reach from the ports is an abort that lands while a copy is in the middle of the chain. A halt that comes after the channel has already gone idle proves nothing. The bench therefore builds a descriptor with a 200-byte count, so that the channel stays busy for hundreds of cycles. It raises abort a fixed number of cycles after start. It then watches the request lines over several cycles before releasing the start bit. The same long descriptor is used to show that a write to the current-descriptor register is ignored while the channel is busy, and that a mode write of zero cuts a copy short.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_WRITE,
        ST_FINISH,
        ST_HALT
    } walk_state_e;

    // register offsets
    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_CUR  = 3'd2;
    localparam logic [2:0] RA_NEXT = 3'd3;
    localparam logic [2:0] RA_LEFT = 3'd4;

    // mode bits
    localparam int MB_START  = 0;
    localparam int MB_ABORT  = 1;
    localparam int MB_ERR_IE = 4;
    localparam int MB_EOS_IE = 5;
    localparam int MB_EOL_IE = 6;

    // status bits
    localparam int SB_EOL  = 0;
    localparam int SB_EOS  = 1;
    localparam int SB_BUSY = 2;
    localparam int SB_HALT = 3;
    localparam int SB_PE   = 4;
    localparam int SB_TE   = 5;

    // link word flags and descriptor alignment
    localparam int LK_EOL   = 0;
    localparam int LK_EOS   = 1;
    localparam int LK_ALIGN = 5;

endpackage

// File: rtl/lds_xfer.sv
module lds_xfer #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_src,
    input  logic          ld_dst,
    input  logic          ld_cnt,
    input  logic [AW-1:0] word,
    input  logic          step,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] remain,
    output logic          last,
    output logic          cnt_zero
);

    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src    <= '0;
            dst    <= '0;
            remain <= '0;
        end else begin
            if (ld_src) begin
                src <= word;
            end else if (step) begin
                src <= src + A_ONE;
            end
            if (ld_dst) begin
                dst <= word;
            end else if (step) begin
                dst <= dst + A_ONE;
            end
            if (ld_cnt) begin
                remain <= word[CW-1:0];
            end else if (step) begin
                remain <= remain - C_ONE;
            end
        end
    end

    assign last     = (remain == C_ONE);
    assign cnt_zero = (remain == '0);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_cnt) |-> (remain != '0));

endmodule

// File: rtl/lds_walker.sv
module lds_walker
    import lds_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   abort_req,
    input  logic                   start_lvl,
    input  logic                   soft_rst,
    input  logic                   sw_cur_we,
    input  logic [AW-LK_ALIGN-1:0] sw_cur_hi,
    output logic                   rd_req,
    output logic [AW-1:0]          rd_addr,
    input  logic                   rd_valid,
    input  logic [31:0]            rd_data,
    input  logic                   rd_err,
    output logic                   wr_req,
    output logic [AW-1:0]          wr_addr,
    output logic [7:0]             wr_data,
    input  logic                   wr_ack,
    input  logic                   wr_err,
    output logic                   busy,
    output logic                   halted,
    output logic                   ev_eol,
    output logic                   ev_eos,
    output logic                   ev_pe,
    output logic                   ev_te,
    output logic [AW-1:0]          cur_desc,
    output logic [31:0]            next_link,
    output logic [CW-1:0]          remain
);

    walk_state_e   state, nxt;
    logic [1:0]    widx;
    logic [7:0]    byte_q;
    logic [AW-1:0] src, dst;
    logic          last, cnt_zero;
    logic          kill, fetch_ok, step;

    assign kill     = soft_rst | (abort_req && state != ST_IDLE && state != ST_HALT);
    assign fetch_ok = (state == ST_FETCH) && rd_valid && !rd_err;
    assign step     = (state == ST_WRITE) && wr_ack && !wr_err && !kill;

    lds_xfer #(.AW(AW), .CW(CW)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_src   (fetch_ok && widx == 2'd0),
        .ld_dst   (fetch_ok && widx == 2'd1),
        .ld_cnt   (fetch_ok && widx == 2'd3),
        .word     (rd_data[AW-1:0]),
        .step     (step),
        .src      (src),
        .dst      (dst),
        .remain   (remain),
        .last     (last),
        .cnt_zero (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_FETCH;
            ST_FETCH:  if (rd_valid) nxt = rd_err ? ST_IDLE :
                                           (widx == 2'd3 ? ST_DECODE : ST_FETCH);
            ST_DECODE: nxt = cnt_zero ? ST_IDLE : ST_READ;
            ST_READ:   if (rd_valid) nxt = rd_err ? ST_IDLE : ST_WRITE;
            ST_WRITE:  if (wr_ack) nxt = wr_err ? ST_IDLE :
                                         (last ? ST_FINISH : ST_READ);
            ST_FINISH: nxt = next_link[LK_EOL] ? ST_IDLE : ST_FETCH;
            ST_HALT:   if (!start_lvl) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (abort_req && state != ST_IDLE && state != ST_HALT) nxt = ST_HALT;
        if (soft_rst) nxt = ST_IDLE;
    end

    // outputs
    always_comb begin
        rd_req  = (state == ST_FETCH) || (state == ST_READ);
        rd_addr = (state == ST_FETCH) ? cur_desc + AW'({widx, 2'b00}) : src;
        wr_req  = (state == ST_WRITE);
        wr_addr = dst;
        wr_data = byte_q;
        busy    = (state != ST_IDLE);
        halted  = (state == ST_HALT);
        ev_te   = !kill && ((rd_req && rd_valid && rd_err) ||
                            (wr_req && wr_ack && wr_err));
        ev_pe   = !kill && (state == ST_DECODE) && cnt_zero;
        ev_eos  = !kill && (state == ST_FINISH) && next_link[LK_EOS];
        ev_eol  = !kill && (state == ST_FINISH) && next_link[LK_EOL];
    end

    // chain datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx      <= '0;
            byte_q    <= '0;
            cur_desc  <= '0;
            next_link <= '0;
        end else begin
            if (state != ST_FETCH) begin
                widx <= '0;
            end else if (fetch_ok) begin
                widx <= widx + 2'd1;
            end
            if (fetch_ok && widx == 2'd2) begin
                next_link <= rd_data;
            end
            if (state == ST_READ && rd_valid && !rd_err) begin
                byte_q <= rd_data[7:0];
            end
            if (sw_cur_we && state == ST_IDLE) begin
                cur_desc <= {sw_cur_hi, {LK_ALIGN{1'b0}}};
            end else if (state == ST_FINISH && !next_link[LK_EOL] && !kill) begin
                cur_desc <= {next_link[AW-1:LK_ALIGN], {LK_ALIGN{1'b0}}};
            end
        end
    end

    // R8
    abort_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && busy && !halted && !soft_rst) |=> halted);

    // R8
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start_lvl) |=> !busy);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rd_req && !wr_req));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !abort_req && !soft_rst) |=> (rd_req && $stable(rd_addr)));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !abort_req && !soft_rst) |=>
        (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R3
    eol_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eol |=> !busy);

    // R5
    pe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pe |=> (!rd_req && !wr_req && !busy));

    // R9
    soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy);

endmodule

// File: rtl/lds_regs.sv
module lds_regs
    import lds_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr_en,
    input  logic [2:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   ev_eol,
    input  logic                   ev_eos,
    input  logic                   ev_pe,
    input  logic                   ev_te,
    input  logic                   busy,
    input  logic                   halted,
    input  logic [AW-1:0]          cur_desc,
    input  logic [31:0]            next_link,
    input  logic [CW-1:0]          remain,
    output logic                   go,
    output logic                   abort_req,
    output logic                   start_lvl,
    output logic                   soft_rst,
    output logic                   sw_cur_we,
    output logic [AW-LK_ALIGN-1:0] sw_cur_hi,
    output logic                   irq
);

    logic [31:0] mode_q;
    logic        start_prev;
    logic        eol_f, eos_f, pe_f, te_f;
    logic        mode_we, stat_we;
    logic [31:0] status;

    assign mode_we   = reg_wr_en && reg_addr == RA_MODE;
    assign stat_we   = reg_wr_en && reg_addr == RA_STAT;
    assign soft_rst  = mode_we && reg_wdata == 32'd0;
    assign sw_cur_we = reg_wr_en && reg_addr == RA_CUR;
    assign sw_cur_hi = reg_wdata[AW-1:LK_ALIGN];

    assign start_lvl = mode_q[MB_START];
    assign abort_req = mode_q[MB_ABORT];
    assign go        = mode_q[MB_START] && !start_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            start_prev <= 1'b0;
        end else begin
            if (mode_we) mode_q <= reg_wdata;
            start_prev <= mode_q[MB_START];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eol_f <= 1'b0;
            eos_f <= 1'b0;
            pe_f  <= 1'b0;
            te_f  <= 1'b0;
        end else if (soft_rst) begin
            eol_f <= 1'b0;
            eos_f <= 1'b0;
            pe_f  <= 1'b0;
            te_f  <= 1'b0;
        end else begin
            if (ev_eol) eol_f <= 1'b1;
            else if (stat_we && reg_wdata[SB_EOL]) eol_f <= 1'b0;
            if (ev_eos) eos_f <= 1'b1;
            else if (stat_we && reg_wdata[SB_EOS]) eos_f <= 1'b0;
            if (ev_pe) pe_f <= 1'b1;
            else if (stat_we && reg_wdata[SB_PE]) pe_f <= 1'b0;
            if (ev_te) te_f <= 1'b1;
            else if (stat_we && reg_wdata[SB_TE]) te_f <= 1'b0;
        end
    end

    always_comb begin
        status          = '0;
        status[SB_EOL]  = eol_f;
        status[SB_EOS]  = eos_f;
        status[SB_BUSY] = busy;
        status[SB_HALT] = halted;
        status[SB_PE]   = pe_f;
        status[SB_TE]   = te_f;
    end

    always_comb begin
        unique case (reg_addr)
            RA_MODE: reg_rdata = mode_q;
            RA_STAT: reg_rdata = status;
            RA_CUR:  reg_rdata = 32'(cur_desc);
            RA_NEXT: reg_rdata = next_link;
            RA_LEFT: reg_rdata = 32'(remain);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (eol_f && mode_q[MB_EOL_IE]) ||
                 (eos_f && mode_q[MB_EOS_IE]) ||
                 ((pe_f || te_f) && mode_q[MB_ERR_IE]);

    // R9
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!eol_f && !eos_f && !pe_f && !te_f && mode_q == '0));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && reg_wdata[5:0] == 6'h3F && !ev_eol && !ev_eos && !ev_pe && !ev_te)
        |=> (!eol_f && !eos_f && !pe_f && !te_f));

    // R12
    single_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

endmodule

// File: rtl/lnk_dma_seq.sv
module lnk_dma_seq
    import lds_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [31:0]   rd_data,
    input  logic          rd_err,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    input  logic          wr_err,
    output logic          irq
);

    logic                   go, abort_req, start_lvl, soft_rst, sw_cur_we;
    logic [AW-LK_ALIGN-1:0] sw_cur_hi;
    logic                   busy, halted;
    logic                   ev_eol, ev_eos, ev_pe, ev_te;
    logic [AW-1:0]          cur_desc;
    logic [31:0]            next_link;
    logic [CW-1:0]          remain;

    lds_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_eol    (ev_eol),
        .ev_eos    (ev_eos),
        .ev_pe     (ev_pe),
        .ev_te     (ev_te),
        .busy      (busy),
        .halted    (halted),
        .cur_desc  (cur_desc),
        .next_link (next_link),
        .remain    (remain),
        .go        (go),
        .abort_req (abort_req),
        .start_lvl (start_lvl),
        .soft_rst  (soft_rst),
        .sw_cur_we (sw_cur_we),
        .sw_cur_hi (sw_cur_hi),
        .irq       (irq)
    );

    lds_walker #(.AW(AW), .CW(CW)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .abort_req (abort_req),
        .start_lvl (start_lvl),
        .soft_rst  (soft_rst),
        .sw_cur_we (sw_cur_we),
        .sw_cur_hi (sw_cur_hi),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_err    (rd_err),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ack    (wr_ack),
        .wr_err    (wr_err),
        .busy      (busy),
        .halted    (halted),
        .ev_eol    (ev_eol),
        .ev_eos    (ev_eos),
        .ev_pe     (ev_pe),
        .ev_te     (ev_te),
        .cur_desc  (cur_desc),
        .next_link (next_link),
        .remain    (remain)
    );

endmodule

// File: tb/test_lnk_dma_seq.sv
module test_lnk_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        rd_req, wr_req, irq;
    logic [31:0] rd_addr, wr_addr;
    logic [7:0]  wr_data;
    logic        rd_valid = 1'b0, rd_err = 1'b0;
    logic [31:0] rd_data = 32'd0;
    logic        wr_ack = 1'b0, wr_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int rcnt = 0;
    int wcnt = 0;
    logic [31:0] rlog [0:255];
    logic [7:0]  mem [0:1023];
    logic        err_rd_en = 1'b0, err_wr_en = 1'b0;
    logic [9:0]  err_addr = 10'd0;

    always #10 clk = ~clk;

    lnk_dma_seq i_lnk_dma_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .wr_err(wr_err), .irq(irq)
    );

    function automatic logic [31:0] rd32(input logic [9:0] a);
        return {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    endfunction

    // memory model: answers one cycle after a request is seen
    always @(negedge clk) begin
        if (rd_req && !rd_valid) begin
            rd_valid <= 1'b1;
            rd_data  <= rd32(rd_addr[9:0]);
            rd_err   <= err_rd_en && (rd_addr[9:0] == err_addr);
            if (rcnt < 256) rlog[rcnt] = rd_addr;
            rcnt = rcnt + 1;
        end else begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
        end
        if (wr_req && !wr_ack) begin
            wr_ack <= 1'b1;
            if (err_wr_en && wr_addr[9:0] == err_addr) begin
                wr_err <= 1'b1;
            end else begin
                wr_err <= 1'b0;
                mem[wr_addr[9:0]] = wr_data;
            end
            wcnt = wcnt + 1;
        end else begin
            wr_ack <= 1'b0;
            wr_err <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        bit done;
        done = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) begin
            @(negedge clk);
            rreg(3'd1, s);
            if (!s[2]) done = 1'b1;
        end
        check(done, tag, 32'd0, 32'd1);
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) % 1024] = v[8*k +: 8];
    endtask

    task automatic put_desc(input int base, input int s, input int d,
                            input logic [31:0] lk, input int n);
        put32(base, s);
        put32(base + 4, d);
        put32(base + 8, lk);
        put32(base + 12, n);
    endtask

    task automatic fill_src(input int s, input int n, input int seed);
        for (int k = 0; k < n; k++) mem[s + k] = 8'((seed * 16 + k * 5 + 3) & 255);
    endtask

    task automatic fill_dst(input int d, input int n);
        for (int k = 0; k < n; k++) mem[d + k] = 8'hEE;
    endtask

    task automatic cmp_copy(input int s, input int d, input int n, input string tag);
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < n; k++) if (mem[d + k] !== mem[s + k]) ok = 1'b0;
        check(ok, tag, 32'(mem[d]), 32'(mem[s]));
        check(mem[d + n] == 8'hEE, {tag, " overrun"}, 32'(mem[d + n]), 32'hEE);
    endtask

    initial begin
        logic [31:0] v;
        bit ok;
        int wc0;
        int rc0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(3'd0, v); check(v == 32'd0, "R1 mode", v, 0);
        rreg(3'd1, v); check(v == 32'd0, "R1 status", v, 0);
        check(!irq && !rd_req && !wr_req, "R1 outputs", {irq, rd_req, wr_req}, 0);

        // single descriptors, byte counts 1..8
        for (int n = 1; n <= 8; n++) begin
            int s;
            s = 32'h100 + n * 3;
            fill_src(s, n, n);
            fill_dst(32'h200, 16);
            put_desc(32'h40, s, 32'h200, 32'h1, n);
            rcnt = 0; wcnt = 0;
            wreg(3'd2, 32'h47);
            wreg(3'd0, 32'h41);
            wait_idle("R2 single done");
            cmp_copy(s, 32'h200, n, "R2 copy");
            check(wcnt == n, "R2 write count", wcnt, n);
            check(rcnt == 4 + n, "R2 read count", rcnt, 4 + n);
            ok = 1'b1;
            for (int k = 0; k < 4; k++) if (rlog[k] != 32'h40 + 4 * k) ok = 1'b0;
            for (int k = 0; k < n; k++) if (rlog[4 + k] != s + k) ok = 1'b0;
            check(ok, "R2 read order", rlog[4], s);
            rreg(3'd1, v); check(v == 32'h1, "R3 eol status", v, 32'h1);
            check(irq == 1'b1, "R10 eol irq", irq, 1);
            rreg(3'd2, v); check(v == 32'h40, "R11 cur", v, 32'h40);
            rreg(3'd3, v); check(v == 32'h1, "R11 next", v, 32'h1);
            rreg(3'd4, v); check(v == 32'h0, "R11 remain", v, 0);
            if (n == 3) begin
                // R12 rewrite with start still set
                rc0 = rcnt;
                wreg(3'd0, 32'h41);
                repeat (20) @(negedge clk);
                check(rcnt == rc0, "R12 no restart", rcnt, rc0);
            end
            wreg(3'd1, 32'h3F);
            @(negedge clk);
            rreg(3'd1, v); check(v == 32'h0, "R7 w1c", v, 0);
            check(irq == 1'b0, "R7 irq after clear", irq, 0);
            wreg(3'd0, 32'h40);
        end

        // R3 R4 chain of three
        fill_src(32'h100, 3, 7); fill_src(32'h140, 2, 8); fill_src(32'h180, 4, 9);
        fill_dst(32'h200, 8); fill_dst(32'h240, 8); fill_dst(32'h280, 8);
        put_desc(32'h00, 32'h100, 32'h200, 32'h22, 3);
        put_desc(32'h20, 32'h140, 32'h240, 32'h7C, 2);
        put_desc(32'h60, 32'h180, 32'h280, 32'h3, 4);
        rcnt = 0; wcnt = 0;
        wreg(3'd2, 32'h0);
        wreg(3'd0, 32'h21);
        wait_idle("R3 chain done");
        cmp_copy(32'h100, 32'h200, 3, "R3 chain seg0");
        cmp_copy(32'h140, 32'h240, 2, "R3 chain seg1");
        cmp_copy(32'h180, 32'h280, 4, "R3 chain seg2");
        check(wcnt == 9, "R3 chain writes", wcnt, 9);
        check(rcnt == 21 && rlog[7] == 32'h20 && rlog[13] == 32'h60,
              "R3 link follow", rlog[13], 32'h60);
        rreg(3'd1, v); check(v == 32'h3, "R4 eos and eol", v, 32'h3);
        rreg(3'd2, v); check(v == 32'h60, "R11 cur after chain", v, 32'h60);
        check(irq == 1'b1, "R10 eos irq", irq, 1);

        // R10 enable sweep with eol+eos set
        for (int m = 1; m < 8; m++) begin
            wreg(3'd0, 32'(m << 4));
            check(irq == (m[2] | m[1]), "R10 sweep", irq, 32'(m[2] | m[1]));
        end
        // R9 mode write of zero clears status
        wreg(3'd0, 32'h0);
        rreg(3'd1, v); check(v == 32'h0, "R9 zero clears", v, 0);

        // R5 zero count
        put_desc(32'h40, 32'h100, 32'h200, 32'h1, 0);
        rcnt = 0; wcnt = 0;
        wreg(3'd2, 32'h40);
        wreg(3'd0, 32'h11);
        wait_idle("R5 done");
        check(rcnt == 4 && wcnt == 0, "R5 no data access", rcnt + wcnt, 4);
        rreg(3'd1, v); check(v == 32'h10, "R5 pe status", v, 32'h10);
        check(irq == 1'b1, "R10 err irq", irq, 1);
        wreg(3'd0, 32'h60);
        check(irq == 1'b0, "R10 err masked", irq, 0);
        wreg(3'd1, 32'h10);
        rreg(3'd1, v); check(v == 32'h0, "R7 pe w1c", v, 0);

        // R6 read error on third source byte
        fill_src(32'h100, 4, 3); fill_dst(32'h200, 8);
        put_desc(32'h40, 32'h100, 32'h200, 32'h1, 4);
        err_addr = 10'h102; err_rd_en = 1'b1; wcnt = 0;
        wreg(3'd0, 32'h11);
        wait_idle("R6 rd done");
        err_rd_en = 1'b0;
        check(wcnt == 2, "R6 rd stop", wcnt, 2);
        rreg(3'd1, v); check(v == 32'h20, "R6 te status", v, 32'h20);
        wreg(3'd1, 32'h20);
        wreg(3'd0, 32'h10);

        // R6 write error on second destination byte
        fill_dst(32'h200, 8);
        err_addr = 10'h201; err_wr_en = 1'b1; wcnt = 0;
        wreg(3'd0, 32'h11);
        wait_idle("R6 wr done");
        err_wr_en = 1'b0;
        check(wcnt == 2 && mem[10'h201] == 8'hEE && mem[10'h202] == 8'hEE,
              "R6 wr stop", 32'(mem[10'h201]), 32'hEE);
        rreg(3'd1, v); check(v == 32'h20, "R6 te wr status", v, 32'h20);
        wreg(3'd1, 32'h20);
        wreg(3'd0, 32'h10);

        // R8 abort during a long copy, R11 write ignored while busy
        put_desc(32'h40, 32'h100, 32'h300, 32'h1, 200);
        wreg(3'd0, 32'h41);
        repeat (40) @(negedge clk);
        wreg(3'd2, 32'h80);
        rreg(3'd2, v); check(v == 32'h40, "R11 cur write ignored busy", v, 32'h40);
        wreg(3'd0, 32'h43);
        @(negedge clk);
        rreg(3'd1, v); check(v == 32'hC, "R8 halted", v, 32'hC);
        wc0 = wcnt; rc0 = rcnt; ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rd_req || wr_req) ok = 1'b0;
        end
        check(ok && wcnt == wc0 && rcnt == rc0, "R8 quiet while halted", wcnt, wc0);
        wreg(3'd0, 32'h40);
        @(negedge clk);
        rreg(3'd1, v); check(v == 32'h0, "R8 idle after release", v, 0);

        // R9 zero mode write mid-copy
        wreg(3'd0, 32'h41);
        repeat (20) @(negedge clk);
        wreg(3'd0, 32'h0);
        @(negedge clk);
        rreg(3'd1, v); check(v == 32'h0, "R9 soft reset idle", v, 0);
        check(!rd_req && !wr_req, "R9 no requests", {rd_req, wr_req}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule